// File: doc/BRIEF.md
# Multiplexed-Address x1 DRAM Functional Model

This block is a synthesizable behavioural stand-in for a single-bit-wide dynamic memory that is addressed through a shared 11-line address bus. A memory controller under test drives the active-low row strobe, column strobe and write enable, plus the address lines and a data-in bit. The model returns a data-out bit with a separate drive enable, which stands for the pin's high-impedance state. All strobes are sampled on a fast system clock. An edge is seen as a change between two consecutive samples, so the controller's strobe timing must be slow compared with that clock.

The row is taken from the address lines when the row strobe falls, and the column when the column strobe falls. Write enable chooses between a read, an early write (write enable already low when the column strobe falls), and a late read-modify-write (write enable falls while read data is already on the output). Consecutive column cycles under one open row give page-mode access. A row-strobe fall while the column strobe is already low is a refresh that uses an internal row counter. A row-strobe cycle with no column strobe refreshes only the addressed row. Each row carries an age counter in system clocks. A sticky error flag records any row that is left unrefreshed for too long. The array size and the refresh limit are parameters.

Top module: `dram_x1_model`

## Requirements
- R1: After reset, q_oe and refresh_err are 0, the refresh row counter is 0 and every cell reads as 0.
- R2: On the first sample with ras_n low after a sample with both strobes high, the row is taken from addr[ROW_W-1:0]. On the first sample with cas_n low while that row is open (opened in an earlier sample, ras_n still low), the column is taken from addr[COL_W-1:0]. The cell index is {row, column}.
- R3: If we_n is high at the column fall, then after that clock edge q_oe is 1 and q_out holds the stored bit of the addressed cell.
- R4: If we_n is low at the column fall, din is written to the addressed cell and q_oe stays 0 for the whole column cycle.
- R5: If we_n falls while cas_n stays low after a read, din from that sample is written to the cell read. q_oe stays 1 and q_out keeps the previously read value.
- R6: A cas_n rise sets q_oe to 0 at that edge. A ras_n rise does not change q_oe or q_out.
- R7: Several column cycles under one open row all use that row, each with its own column.
- R8: A ras_n fall while cas_n was low in the previous sample refreshes the row given by the internal counter. The counter then advances, wrapping modulo 2^ROW_W. No cell is read or written, and q_oe and q_out keep their values, so data read before a hidden refresh stays driven.
- R9: A ras_n fall with cas_n high refreshes the addressed row. Without a column fall, this cycle does not drive q_oe.
- R10: Each row counts system clocks since its last refresh, saturating at REFRESH_LIMIT. At the edge after any row's count has reached REFRESH_LIMIT, refresh_err becomes 1, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| q_out | output | 1 | Read data bit, meaningful when q_oe is 1 |
| q_oe | output | 1 | Output drive enable; 0 stands for high impedance |
| refresh_err | output | 1 | Sticky refresh-interval violation flag |

## Verification
The following output-timing rules are checked by assertions on every clock:
- An early write never turns the output on.
- A column-strobe rise always releases the output.
- A row-strobe rise and a late write both leave the driven value untouched.
- The output is only ever driven in the clock after a low column strobe.
- The error flag never clears.

Cell contents, page-mode row reuse, the refresh counter's row order and the exact clock on which a refresh violation appears can only be shown by the bench's scenarios. Its per-cycle reference model exposes them through read-back values and the timing of refresh_err.

// File: rtl/dram_pkg.sv
package dram_pkg;
    localparam int ADDR_W = 11;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ACCESS = 2'd1,
        CYC_CBR    = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] prev,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = strobe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign prev = prev_q;
    assign fall = prev_q & ~strobe;
    assign rise = ~prev_q & strobe;
endmodule

// File: rtl/dram_refresh_monitor.sv
module dram_refresh_monitor #(
    parameter int ROW_W = 4,
    parameter int LIMIT = 3200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [ROW_W-1:0] hit_row,
    output logic             err
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int AGE_W = $clog2(LIMIT + 1);
    localparam logic [AGE_W-1:0] LIM = AGE_W'(LIMIT);

    logic [ROWS-1:0] at_limit;
    logic err_d, err_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [AGE_W-1:0] age_d, age_q;

        always_comb begin
            if (hit && (hit_row == ROW_W'(r))) age_d = '0;
            else if (age_q == LIM)             age_d = age_q;
            else                               age_d = age_q + AGE_W'(1);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) age_q <= '0;
            else        age_q <= age_d;
        end

        assign at_limit[r] = (age_q == LIM);
    end

    always_comb begin
        err_d = err_q | (|at_limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err = err_q;
endmodule

// File: rtl/dram_x1_model.sv
module dram_x1_model
    import dram_pkg::*;
#(
    parameter int ROW_W         = 4,
    parameter int COL_W         = 4,
    parameter int REFRESH_LIMIT = 3200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              q_out,
    output logic              q_oe,
    output logic              refresh_err
);
    localparam int CELL_W = ROW_W + COL_W;
    localparam int CELLS  = 1 << CELL_W;

    typedef struct packed {
        cyc_kind_e        kind;
        logic             rd_live;
        logic             q_oe;
        logic             q_bit;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] rcnt;
        logic [CELLS-1:0] mem;
    } state_t;

    state_t s_d, s_q;

    logic [2:0] prev, fall, rise;
    logic ref_hit;
    logic [ROW_W-1:0] ref_row;
    logic [CELL_W-1:0] rd_idx, wr_idx;

    dram_strobe_edges #(.N(3)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe ({ras_n, cas_n, we_n}),
        .prev   (prev),
        .fall   (fall),
        .rise   (rise)
    );

    wire ras_fall = fall[2];
    wire ras_rise = rise[2];
    wire cas_fall = fall[1];
    wire cas_rise = rise[1];
    wire we_fall  = fall[0];
    wire cas_prev = prev[1];

    assign rd_idx = {s_q.row, addr[COL_W-1:0]};
    assign wr_idx = {s_q.row, s_q.col};

    always_comb begin
        s_d     = s_q;
        ref_hit = 1'b0;
        ref_row = '0;

        // Row strobe: open a row, or refresh from the counter.
        if (ras_fall) begin
            ref_hit = 1'b1;
            if (!cas_prev) begin
                ref_row = s_q.rcnt;
                s_d.rcnt = s_q.rcnt + ROW_W'(1);
                s_d.kind = CYC_CBR;
            end else begin
                ref_row  = addr[ROW_W-1:0];
                s_d.row  = addr[ROW_W-1:0];
                s_d.kind = CYC_ACCESS;
            end
        end
        if (ras_rise) begin
            s_d.kind = CYC_IDLE;
        end

        // Column strobe fall inside an open row.
        if (cas_fall && (s_q.kind == CYC_ACCESS) && !ras_n) begin
            s_d.col = addr[COL_W-1:0];
            if (!we_n) begin
                s_d.mem[rd_idx] = din;
                s_d.q_oe        = 1'b0;
                s_d.rd_live     = 1'b0;
            end else begin
                s_d.q_bit   = s_q.mem[rd_idx];
                s_d.q_oe    = 1'b1;
                s_d.rd_live = 1'b1;
            end
        end

        // Late write: output holds the value already read.
        if (we_fall && !cas_n && !cas_fall && s_q.rd_live) begin
            s_d.mem[wr_idx] = din;
        end

        if (cas_rise) begin
            s_d.q_oe    = 1'b0;
            s_d.rd_live = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dram_refresh_monitor #(.ROW_W(ROW_W), .LIMIT(REFRESH_LIMIT)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (ref_hit),
        .hit_row (ref_row),
        .err     (refresh_err)
    );

    assign q_out = s_q.q_bit;
    assign q_oe  = s_q.q_oe;
endmodule

// File: rtl/dram_x1_model_checker.sv
module dram_x1_model_checker (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic q_out,
    input logic q_oe,
    input logic refresh_err
);
    assert_early_write_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |=> !q_oe);

    assert_cas_rise_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |=> !q_oe);

    assert_ras_rise_keeps_q_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && !cas_n && !$past(cas_n)) |=> ($stable(q_oe) && $stable(q_out)));

    assert_drive_after_cas_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_oe |-> !$past(cas_n));

    assert_late_write_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !$past(cas_n) && $fell(we_n) && q_oe) |=> (q_oe && $stable(q_out)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_err |=> refresh_err);
endmodule

bind dram_x1_model dram_x1_model_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .q_out       (q_out),
    .q_oe        (q_oe),
    .refresh_err (refresh_err)
);

// File: tb/dram_x1_model_bench.sv
`timescale 1ns/1ps
module dram_x1_model_bench;
    localparam int RW    = 4;
    localparam int CW    = 4;
    localparam int NROWS = 16;
    localparam int NCOLS = 16;
    localparam int LIM   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [10:0] addr = '0;
    logic q_out, q_oe, refresh_err;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit m_mem [NROWS*NCOLS];
    int m_age [NROWS];
    bit m_err, m_oe, m_q, m_rd;
    bit m_rp, m_cp, m_wp;
    int m_kind, m_row, m_col, m_cnt;

    always #2.5 clk = ~clk;

    dram_x1_model #(.ROW_W(RW), .COL_W(CW), .REFRESH_LIMIT(LIM)) u_dram_x1_model (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .q_out(q_out), .q_oe(q_oe), .refresh_err(refresh_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        foreach (m_mem[i]) m_mem[i] = 1'b0;
        foreach (m_age[i]) m_age[i] = 0;
        m_err = 0; m_oe = 0; m_q = 0; m_rd = 0;
        m_rp = 1; m_cp = 1; m_wp = 1;
        m_kind = 0; m_row = 0; m_col = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit rf, rr, cf, cr, wf, o_rd;
        int hit, o_kind, o_row, o_col;
        rf = m_rp && !ras_n; rr = !m_rp && ras_n;
        cf = m_cp && !cas_n; cr = !m_cp && cas_n;
        wf = m_wp && !we_n;
        o_kind = m_kind; o_row = m_row; o_col = m_col; o_rd = m_rd;
        hit = -1;
        for (int r = 0; r < NROWS; r++) if (m_age[r] == LIM) m_err = 1;
        if (rf) begin
            if (!m_cp) begin
                hit = m_cnt; m_cnt = (m_cnt + 1) % NROWS; m_kind = 2;
            end else begin
                hit = int'(addr) % NROWS; m_row = hit; m_kind = 1;
            end
        end
        if (rr) m_kind = 0;
        if (cf && o_kind == 1 && !ras_n) begin
            m_col = int'(addr) % NCOLS;
            if (!we_n) begin
                m_mem[o_row*NCOLS + m_col] = din; m_oe = 0; m_rd = 0;
            end else begin
                m_q = m_mem[o_row*NCOLS + m_col]; m_oe = 1; m_rd = 1;
            end
        end
        if (wf && !cas_n && !cf && o_rd) m_mem[o_row*NCOLS + o_col] = din;
        if (cr) begin m_oe = 0; m_rd = 0; end
        for (int r = 0; r < NROWS; r++) begin
            if (r == hit) m_age[r] = 0;
            else if (m_age[r] < LIM) m_age[r]++;
        end
        m_rp = ras_n; m_cp = cas_n; m_wp = we_n;
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        chk("R6 per-cycle q_oe", q_oe, m_oe);
        if (m_oe) chk("R3 per-cycle q_out", q_out, m_q);
        chk("R10 per-cycle refresh_err", refresh_err, m_err);
    endtask

    task automatic open_row(input int r);
        addr = 11'(r); ras_n = 0; cyc(); cyc();
    endtask

    task automatic close_row();
        cas_n = 1; we_n = 1; ras_n = 1; cyc(); cyc();
    endtask

    task automatic cas_read(input int c, input bit exp, input string tag);
        addr = 11'(c); we_n = 1; cas_n = 0; cyc();
        chk({tag, " read drive"}, q_oe, 1'b1);
        chk({tag, " read value"}, q_out, exp);
        cas_n = 1; cyc();
        chk("R6 release on cas rise", q_oe, 1'b0);
    endtask

    task automatic cas_ewrite(input int c, input bit d);
        addr = 11'(c); we_n = 0; din = d; cas_n = 0; cyc();
        chk("R4 early write hi-z", q_oe, 1'b0);
        cyc();
        chk("R4 early write hi-z held", q_oe, 1'b0);
        cas_n = 1; we_n = 1; cyc();
    endtask

    task automatic cbr_once();
        cas_n = 0; cyc(); ras_n = 0; cyc(); cyc();
        ras_n = 1; cas_n = 1; cyc();
    endtask

    initial begin
        model_reset();
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R1 reset q_oe", q_oe, 1'b0);
        chk("R1 reset refresh_err", refresh_err, 1'b0);

        // R8: full counter sweep
        for (int i = 0; i < NROWS; i++) cbr_once();
        chk("R8 sweep keeps q off", q_oe, 1'b0);

        // R1: untouched cell reads 0
        open_row(5); cas_read(3, 1'b0, "R1"); close_row();

        // R2 / R4: writes at distinct rows and columns
        open_row(2); cas_ewrite(1, 1'b1); close_row();
        open_row(9); cas_ewrite(1, 1'b0); cas_ewrite(14, 1'b1); close_row();
        open_row(9); cas_read(14, 1'b1, "R2"); cas_read(1, 1'b0, "R2"); close_row();

        // R7: page mode in row 2
        open_row(2);
        cas_ewrite(6, 1'b1);
        cas_read(1, 1'b1, "R7");
        cas_read(6, 1'b1, "R7");
        cas_read(14, 1'b0, "R7");
        close_row();

        // R5: late write
        open_row(9);
        addr = 11'd14; we_n = 1; cas_n = 0; cyc();
        chk("R3 read before late write", q_out, 1'b1);
        din = 0; we_n = 0; cyc();
        chk("R5 q held on late write", q_oe, 1'b1);
        chk("R5 q value held", q_out, 1'b1);
        ras_n = 1; cyc();
        chk("R6 ras rise keeps q", q_oe, 1'b1);
        cas_n = 1; we_n = 1; cyc();
        open_row(9); cas_read(14, 1'b0, "R5"); close_row();

        // R8: hidden refresh
        open_row(2);
        addr = 11'd6; we_n = 1; cas_n = 0; cyc();
        ras_n = 1; cyc(); cyc();
        ras_n = 0; cyc(); cyc();
        chk("R8 hidden refresh drive", q_oe, 1'b1);
        chk("R8 hidden refresh value", q_out, 1'b1);
        ras_n = 1; cyc();
        cas_n = 1; cyc();
        chk("R6 release after hidden refresh", q_oe, 1'b0);

        // R9: row-only refresh
        addr = 11'd7; ras_n = 0; cyc(); cyc(); cyc();
        chk("R9 row-only refresh no drive", q_oe, 1'b0);
        ras_n = 1; cyc();

        chk("R10 no error while refreshed", refresh_err, 1'b0);
        for (int i = 0; i < NROWS; i++) cbr_once();
        repeat (LIM + 10) cyc();
        chk("R10 error after limit", refresh_err, 1'b1);
        for (int i = 0; i < NROWS; i++) cbr_once();
        chk("R10 error sticky", refresh_err, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule